// File: doc/BRIEF.md
# Chip-Select Gated Registered Fanout Buffer

This block registers a memory command/address bus and drives each registered signal out as two identical copies, A and B, so that two groups of loads can be fed from one input bus. Twenty-two data lines can be captured on every rising clock edge. Alternatively, they are captured only on edges where a command is present, which means at least one of the two active-low chip selects is low. A mode input called `gate_en` picks between these two behaviours.

The two chip selects, the two clock-enable lines and the two termination-control lines are registered on every rising edge, whatever the mode. Only the data lines are subject to gating. When an edge is gated off, the data outputs keep their old values.

An active-low reset clears every register at once, with no clock needed. Its release is synchronised to the clock, so the registers leave reset cleanly.

Top module: `cs_gated_fanout_reg`

## Requirements
- R1: With `gate_en` low, `q_a`/`q_b` take the value `d` had at each rising edge, whatever the chip selects are, and show it one cycle later.
- R2: With `gate_en` high, `d` is captured on a rising edge where at least one bit of `cs_n` is 0.
- R3: With `gate_en` high, `q_a`/`q_b` keep their previous value on a rising edge where both `cs_n` bits are 1.
- R4: `qcke_a`/`qcke_b` and `qodt_a`/`qodt_b` take `cke` and `odt` on every rising edge, in either mode and for any chip-select value.
- R5: `qcs_a_n`/`qcs_b_n` take `cs_n` on every rising edge, bit for bit, in either mode.
- R6: Every A output equals its B counterpart in every cycle.
- R7: While `rst_n` is 0, every output is 0. The clear takes effect as soon as `rst_n` falls, without waiting for a clock edge.
- R8: After `rst_n` rises, all outputs stay 0 through the first two rising edges. The third rising edge is the first one that captures inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_en | input | 1 | 1: capture data only when a chip select is low; 0: capture data on every edge |
| cs_n | input | 2 | Active-low chip selects |
| d | input | 22 | Data lines, subject to gating |
| cke | input | 2 | Clock-enable lines, never gated |
| odt | input | 2 | Termination-control lines, never gated |
| q_a | output | 22 | Registered data, copy A |
| q_b | output | 22 | Registered data, copy B |
| qcs_a_n | output | 2 | Registered chip selects, copy A |
| qcs_b_n | output | 2 | Registered chip selects, copy B |
| qcke_a | output | 2 | Registered clock enables, copy A |
| qcke_b | output | 2 | Registered clock enables, copy B |
| qodt_a | output | 2 | Registered termination controls, copy A |
| qodt_b | output | 2 | Registered termination controls, copy B |

## Verification
With gating on, an edge where both chip selects are high suppresses the data capture. On that same edge the chip-select, clock-enable and termination registers must still load new values. The bench provokes this with random chip-select pairs that include 11, while `cke`, `odt` and `d` all change on each cycle. A scoreboard model holds the old data word and loads the new control values, and every output is compared against it one cycle later. A second collision is forced by pulling `rst_n` low a few nanoseconds after a capturing edge. The outputs are then checked for zero before the next edge, and again after it.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int COPIES = 2;
  localparam int COPY_A = 0;
  localparam int COPY_B = 1;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/csf_rst_sync.sv
module csf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/csf_gate.sv
module csf_gate #(
  parameter int NUM_CS = 2
) (
  input  logic              gate_en,
  input  logic [NUM_CS-1:0] cs_n,
  output logic              cap_en
);
  logic any_sel;

  always_comb begin
    any_sel = (cs_n != {NUM_CS{1'b1}});
    cap_en  = !gate_en || any_sel;
  end
endmodule

// File: rtl/csf_dual_reg.sv
module csf_dual_reg #(
  parameter int W      = 8,
  parameter int COPIES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [W-1:0]              d,
  output logic [COPIES-1:0][W-1:0]  q
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [W-1:0] r_q, r_d;

    always_comb r_d = en ? d : r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= r_d;
    end

    assign q[c] = r_q;
  end
endmodule

// File: rtl/cs_gated_fanout_reg.sv
module cs_gated_fanout_reg
  import csf_pkg::*;
#(
  parameter int DATA_W  = 22,
  parameter int NUM_CS  = 2,
  parameter int NUM_CKE = 2,
  parameter int NUM_ODT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_en,
  input  logic [NUM_CS-1:0]  cs_n,
  input  logic [DATA_W-1:0]  d,
  input  logic [NUM_CKE-1:0] cke,
  input  logic [NUM_ODT-1:0] odt,
  output logic [DATA_W-1:0]  q_a,
  output logic [DATA_W-1:0]  q_b,
  output logic [NUM_CS-1:0]  qcs_a_n,
  output logic [NUM_CS-1:0]  qcs_b_n,
  output logic [NUM_CKE-1:0] qcke_a,
  output logic [NUM_CKE-1:0] qcke_b,
  output logic [NUM_ODT-1:0] qodt_a,
  output logic [NUM_ODT-1:0] qodt_b
);
  localparam int CTL_W = NUM_CS + NUM_CKE + NUM_ODT;

  logic                          rst_n_int;
  logic                          data_en;
  logic [CTL_W-1:0]              ctl_in;
  logic [COPIES-1:0][CTL_W-1:0]  ctl_q;
  logic [COPIES-1:0][DATA_W-1:0] data_q;

  csf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  csf_gate #(.NUM_CS(NUM_CS)) u_gate (
    .gate_en(gate_en), .cs_n(cs_n), .cap_en(data_en)
  );

  csf_dual_reg #(.W(DATA_W), .COPIES(COPIES)) u_data (
    .clk(clk), .rst_n(rst_n_int), .en(data_en), .d(d), .q(data_q)
  );

  assign ctl_in = {cs_n, cke, odt};

  csf_dual_reg #(.W(CTL_W), .COPIES(COPIES)) u_ctl (
    .clk(clk), .rst_n(rst_n_int), .en(1'b1), .d(ctl_in), .q(ctl_q)
  );

  assign q_a     = data_q[COPY_A];
  assign q_b     = data_q[COPY_B];
  assign qcs_a_n = ctl_q[COPY_A][CTL_W-1 -: NUM_CS];
  assign qcs_b_n = ctl_q[COPY_B][CTL_W-1 -: NUM_CS];
  assign qcke_a  = ctl_q[COPY_A][NUM_ODT +: NUM_CKE];
  assign qcke_b  = ctl_q[COPY_B][NUM_ODT +: NUM_CKE];
  assign qodt_a  = ctl_q[COPY_A][0 +: NUM_ODT];
  assign qodt_b  = ctl_q[COPY_B][0 +: NUM_ODT];
endmodule

// File: rtl/csf_chk.sv
module csf_chk #(
  parameter int DATA_W  = 22,
  parameter int NUM_CS  = 2,
  parameter int NUM_CKE = 2,
  parameter int NUM_ODT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gate_en,
  input logic [NUM_CS-1:0]  cs_n,
  input logic [DATA_W-1:0]  d,
  input logic [NUM_CKE-1:0] cke,
  input logic [NUM_ODT-1:0] odt,
  input logic [DATA_W-1:0]  q_a,
  input logic [DATA_W-1:0]  q_b,
  input logic [NUM_CS-1:0]  qcs_a_n,
  input logic [NUM_CS-1:0]  qcs_b_n,
  input logic [NUM_CKE-1:0] qcke_a,
  input logic [NUM_CKE-1:0] qcke_b,
  input logic [NUM_ODT-1:0] qodt_a,
  input logic [NUM_ODT-1:0] qodt_b
);
  logic [1:0] since_rel;
  logic       live;
  logic       all_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rel <= 2'd0;
    else if (since_rel != 2'd3) since_rel <= since_rel + 2'd1;
  end

  assign live     = (since_rel == 2'd3);
  assign all_zero = (q_a == '0) && (q_b == '0) && (qcs_a_n == '0) && (qcs_b_n == '0)
                 && (qcke_a == '0) && (qcke_b == '0) && (qodt_a == '0) && (qodt_b == '0);

  // R1
  open_mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(gate_en)) |-> (q_a == $past(d)));

  // R2
  gated_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(gate_en) && ($past(cs_n) != '1)) |-> (q_a == $past(d)));

  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(gate_en) && ($past(cs_n) == '1)) |-> $stable(q_a));

  // R4
  ungated_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (qcke_a == $past(cke) && qodt_a == $past(odt)));

  // R5
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (qcs_a_n == $past(cs_n)));

  // R6
  copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_a == q_b && qcs_a_n == qcs_b_n && qcke_a == qcke_b && qodt_a == qodt_b));

  // R7
  reset_clear_chk: assert property (@(negedge clk) !rst_n |-> all_zero);

  // R8
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rel != 2'd3) |-> all_zero);
endmodule

bind cs_gated_fanout_reg csf_chk #(
  .DATA_W(DATA_W), .NUM_CS(NUM_CS), .NUM_CKE(NUM_CKE), .NUM_ODT(NUM_ODT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n(cs_n), .d(d), .cke(cke), .odt(odt),
  .q_a(q_a), .q_b(q_b), .qcs_a_n(qcs_a_n), .qcs_b_n(qcs_b_n),
  .qcke_a(qcke_a), .qcke_b(qcke_b), .qodt_a(qodt_a), .qodt_b(qodt_b)
);

// File: tb/cs_gated_fanout_reg_tb.sv
module cs_gated_fanout_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gate_en;
  logic [1:0]  cs_n, cke, odt;
  logic [21:0] d;
  logic [21:0] q_a, q_b;
  logic [1:0]  qcs_a_n, qcs_b_n, qcke_a, qcke_b, qodt_a, qodt_b;

  typedef struct { logic [21:0] d; logic [1:0] cs; logic [1:0] cke; logic [1:0] odt; } exp_t;
  exp_t        sb[$];
  logic [21:0] model_d;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cs_gated_fanout_reg u_dut (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .cs_n(cs_n), .d(d), .cke(cke), .odt(odt),
    .q_a(q_a), .q_b(q_b), .qcs_a_n(qcs_a_n), .qcs_b_n(qcs_b_n),
    .qcke_a(qcke_a), .qcke_b(qcke_b), .qodt_a(qodt_a), .qodt_b(qodt_b)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_zero(string tag);
    chk(tag, {q_a, q_b, qcs_a_n, qcs_b_n, qcke_a, qcke_b, qodt_a, qodt_b}, 64'd0);
  endtask

  // driver: applies one cycle of stimulus and pushes the model's expectation
  task automatic drive(logic g, logic [1:0] c, logic [21:0] dv, logic [1:0] k, logic [1:0] o);
    exp_t e;
    @(negedge clk);
    gate_en = g; cs_n = c; d = dv; cke = k; odt = o;
    if (!g || c != 2'b11) model_d = dv;
    e.d = model_d; e.cs = c; e.cke = k; e.odt = o;
    sb.push_back(e);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(gate_en ? "R2/R3 data" : "R1 data", {42'd0, q_a}, {42'd0, e.d});
      chk("R4 cke/odt", {60'd0, qcke_a, qodt_a}, {60'd0, e.cke, e.odt});
      chk("R5 cs", {62'd0, qcs_a_n}, {62'd0, e.cs});
      chk("R6 copies", {q_b, qcs_b_n, qcke_b, qodt_b}, {q_a, qcs_a_n, qcke_a, qodt_a});
    end
  end

  task automatic release_seq(logic [21:0] dv);
    @(negedge clk);
    gate_en = 1'b0; cs_n = 2'b10; d = dv; cke = 2'b11; odt = 2'b01;
    #2 rst_n = 1'b1;
    @(posedge clk); #2 chk_zero("R8 edge1");
    @(posedge clk); #2 chk_zero("R8 edge2");
    @(posedge clk); #2
    chk("R8 edge3", {q_a, qcs_a_n, qcke_a, qodt_a}, {dv, 2'b10, 2'b11, 2'b01});
    model_d = dv;
  endtask

  initial begin
    rst_n = 1'b0; gate_en = 1'b0; cs_n = 2'b11; d = '0; cke = '0; odt = '0;
    repeat (3) @(posedge clk);
    #2 chk_zero("R7 reset state");
    release_seq(22'h2A5A5A);

    // open mode, chip selects including both high
    for (int i = 0; i < 40; i++)
      drive(1'b0, 2'($urandom), 22'($urandom), 2'($urandom), 2'($urandom));
    drive(1'b0, 2'b11, 22'h3FFFFF, 2'b00, 2'b11);
    // gated mode: each chip-select pattern in turn, then random
    drive(1'b1, 2'b11, 22'h000001, 2'b01, 2'b10);
    drive(1'b1, 2'b01, 22'h155555, 2'b10, 2'b01);
    drive(1'b1, 2'b11, 22'h0ABCDE, 2'b11, 2'b00);
    drive(1'b1, 2'b10, 22'h123456, 2'b00, 2'b11);
    drive(1'b1, 2'b00, 22'h3C3C3C, 2'b01, 2'b01);
    drive(1'b1, 2'b11, 22'h000000, 2'b10, 2'b10);
    for (int i = 0; i < 60; i++)
      drive(1'b1, 2'($urandom), 22'($urandom), 2'($urandom), 2'($urandom));
    wait (sb.size() == 0);
    @(posedge clk); #4;

    // reset falling between edges
    @(posedge clk); #3 rst_n = 1'b0;
    #1 chk_zero("R7 async clear");
    @(posedge clk); #2 chk_zero("R7 held through edge");
    release_seq(22'h0F0F0F);

    for (int i = 0; i < 40; i++)
      drive(1'($urandom), 2'($urandom), 22'($urandom), 2'($urandom), 2'($urandom));
    wait (sb.size() == 0);
    @(posedge clk); #4;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule